// File: doc/BRIEF.md
# Translation Buffer Slot Allocator with Entry Locking

This block holds a small fully associative set of address translation entries and decides where each new entry goes. Every slot stores a virtual page number, a two-bit page size code, a context number, a partition number, a real-address flag, the physical page, and three state bits: valid, used and locked. One command is accepted per clock: insert, demap by page, demap by context, demap by partition, or flush. A combinational read port returns a tag word or a data word for any slot, and a combinational lookup reports whether a key hits a valid entry.

An insert first removes every valid entry whose tag overlaps the new one. It then picks a slot. An explicit index wins. Otherwise the lowest-indexed empty slot is used. When no slot is empty, a rotating replacement pointer walks past locked slots. If every other slot is locked, the highest slot is overwritten. The used bits follow a simple aging rule: when an insert leaves every slot marked used, they are all cleared again, except on locked entries and on the slot just written.

Page size code s covers 2^(3·s) base pages. The low 3·s bits of the page number are ignored when two entries are compared.

Top module: `tlb_alloc`

## Requirements
- R1: After a synchronous active-low reset, no slot is valid, every read-port word is all ones and `used_count` is 0.
- R2: An insert (`op_code` 1) with `op_at_idx` low writes the lowest-indexed empty slot when one exists, and marks it valid and used.
- R3: Before the slot is chosen, an insert invalidates every valid entry that has the same context, partition and real flag and whose page range overlaps the new range. Slots freed this way can receive the new entry.
- R4: An insert with `op_at_idx` high writes slot `op_idx`, which must be below ENTRIES, whether or not that slot is occupied.
- R5: With no empty slot, the victim is the first unlocked slot found by stepping from the pointer position plus one, wrapping at ENTRIES. The pointer then rests on that victim. It does not move on any other cycle.
- R6: If every slot other than the pointer position is locked, an insert overwrites slot ENTRIES-1 and the pointer does not move.
- R7: Demap-page (`op_code` 2) removes valid entries that match the context, partition and real flag and whose page covers `op_vpn`. Demap-context (code 3) removes entries that match the context and partition. Both act on locked entries too. Demap-partition (code 4) removes only unlocked entries of that partition.
- R8: Flush (`op_code` 5) invalidates all slots and sets `used_count` to 0.
- R9: `used_count` equals the number of slots whose used bit is set. Invalidating a slot clears its used bit. When an insert leaves every slot used, only the locked slots and the slot just written stay used.
- R10: With `rd_sel` 0, a valid slot reads as ctx | (vpn << 13) | (partition << 61) | (real << 60) | ((7 XOR size) << 56). An invalid slot reads as all ones.
- R11: With `rd_sel` 1, a valid slot reads as bit 63 = 1, bit 62 = locked, the physical page from bit 13 up and the size code in bits 1:0. An invalid slot reads as all ones.
- R12: `lk_hit` is high when a valid entry matches the lookup context, partition and real flag and its page covers `lk_vpn`. `lk_ppn` is then that entry's physical page, taking the lowest index if several entries match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 3 | Command: 1 insert, 2 demap page, 3 demap context, 4 demap partition, 5 flush |
| op_vpn | input | VPN_W | Virtual page number of the command |
| op_size | input | 2 | Page size code for insert |
| op_ctx | input | CTX_W | Context number |
| op_part | input | PART_W | Partition number |
| op_real | input | 1 | Real-address flag |
| op_lock | input | 1 | Locked bit for the inserted entry |
| op_ppn | input | PPN_W | Physical page for insert |
| op_at_idx | input | 1 | Insert at an explicit slot |
| op_idx | input | IDX_W | Explicit slot index |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_ctx | input | CTX_W | Lookup context |
| lk_part | input | PART_W | Lookup partition |
| lk_real | input | 1 | Lookup real flag |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_ppn | output | PPN_W | Physical page of the matching entry |
| rd_idx | input | IDX_W | Slot to read |
| rd_sel | input | 1 | 0 tag word, 1 data word |
| rd_word | output | 64 | Read-port word |
| used_count | output | CNT_W | Number of slots marked used |

## Verification
The bench builds the block with ENTRIES = 4, VPN_W = 20, CTX_W = 13, PART_W = 3 and PPN_W = 24. With only four slots, a handful of inserts fills the buffer. That makes all of these reachable in a short run: the full-buffer replacement walk, the wrap of the pointer past locked slots, the all-locked fallback to the last slot, and the used-bit aging reset. Size code 1 is used next to size code 0, so that overlapping conflicts and covered lookups at a non-zero page offset are exercised as well.

// File: rtl/tlb_alloc_pkg.sv
// Shared command encoding for the translation buffer allocator.
// Assumes a three-bit command field on the top-level port.
package tlb_alloc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_INSERT    = 3'd1,
        CMD_DMAP_PAGE = 3'd2,
        CMD_DMAP_CTX  = 3'd3,
        CMD_DMAP_PART = 3'd4,
        CMD_FLUSH     = 3'd5
    } tlb_cmd_e;

    localparam int TAG_VA_LSB   = 13;
    localparam int TAG_SIZE_LSB = 56;
    localparam int TAG_REAL_BIT = 60;
    localparam int TAG_PART_LSB = 61;

endpackage

// File: rtl/tlb_alloc_match.sv
// Compares one stored entry against a key.
// Size code s ignores the low STEP*s bits of the page number.
// Assumes STEP*3 stays below VPN_W.
module tlb_alloc_match #(
    parameter int VPN_W  = 20,
    parameter int CTX_W  = 13,
    parameter int PART_W = 3,
    parameter int STEP   = 3
) (
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [1:0]        e_size,
    input  logic [CTX_W-1:0]  e_ctx,
    input  logic [PART_W-1:0] e_part,
    input  logic              e_real,
    input  logic [VPN_W-1:0]  k_vpn,
    input  logic [1:0]        k_size,
    input  logic [CTX_W-1:0]  k_ctx,
    input  logic [PART_W-1:0] k_part,
    input  logic              k_real,
    output logic              overlap,
    output logic              covers,
    output logic              same_ctx,
    output logic              same_part,
    output logic              same_space
);

    function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] s);
        logic [VPN_W-1:0] m;
        for (int i = 0; i < VPN_W; i++) m[i] = (i < STEP * int'(s));
        return m;
    endfunction

    logic [VPN_W-1:0] diff;

    // Field equality and range tests for one entry
    always_comb begin
        diff       = e_vpn ^ k_vpn;
        overlap    = ((diff & ~(size_mask(e_size) | size_mask(k_size))) == '0);
        covers     = ((diff & ~size_mask(e_size)) == '0);
        same_ctx   = (e_ctx == k_ctx);
        same_part  = (e_part == k_part);
        same_space = same_part && (e_real == k_real);
    end

endmodule

// File: rtl/tlb_alloc_victim.sv
// Chooses the slot an insert writes. The order is: explicit index,
// then the lowest empty slot, then a rotating walk that skips locked
// slots. When every other slot is locked, the last slot is chosen.
// Assumes ENTRIES >= 1 and idx < ENTRIES.
module tlb_alloc_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] free_vec,
    input  logic [ENTRIES-1:0] lock_vec,
    input  logic [IDX_W-1:0]   ptr,
    input  logic               at_idx,
    input  logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   victim,
    output logic               advance
);

    logic             any_free;
    logic [IDX_W-1:0] low_free;
    logic             rot_found;
    logic [IDX_W-1:0] rot_pick;

    // Priority encoder over the empty slots, lowest index wins
    always_comb begin
        any_free = |free_vec;
        low_free = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (free_vec[i]) low_free = IDX_W'(i);
    end

    // Rotating walk from ptr+1; the nearest unlocked slot wins
    always_comb begin
        rot_found = 1'b0;
        rot_pick  = IDX_W'(ENTRIES - 1);
        for (int k = ENTRIES - 1; k >= 1; k--) begin
            int j;
            j = (int'(ptr) + k) % ENTRIES;
            if (!lock_vec[j]) begin
                rot_found = 1'b1;
                rot_pick  = IDX_W'(j);
            end
        end
    end

    // Final selection and pointer-advance decision
    always_comb begin
        if (at_idx)        victim = idx;
        else if (any_free) victim = low_free;
        else               victim = rot_pick;
        advance = !at_idx && !any_free && rot_found;
    end

endmodule

// File: rtl/tlb_alloc.sv
// Fully associative translation buffer: slot allocation with locking,
// conflict removal, demap commands, a diagnostic read port and a
// single-cycle lookup. One command per clock. Reset is synchronous and
// active low.
module tlb_alloc
    import tlb_alloc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int CTX_W   = 13,
    parameter int PART_W  = 3,
    parameter int PPN_W   = 24,
    parameter int STEP    = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [VPN_W-1:0]  op_vpn,
    input  logic [1:0]        op_size,
    input  logic [CTX_W-1:0]  op_ctx,
    input  logic [PART_W-1:0] op_part,
    input  logic              op_real,
    input  logic              op_lock,
    input  logic [PPN_W-1:0]  op_ppn,
    input  logic              op_at_idx,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic [PART_W-1:0] lk_part,
    input  logic              lk_real,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_sel,
    output logic [63:0]       rd_word,
    output logic [CNT_W-1:0]  used_count
);

    logic [ENTRIES-1:0] valid_q, used_q, lock_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [1:0]         size_q [ENTRIES];
    logic [CTX_W-1:0]   ctx_q  [ENTRIES];
    logic [PART_W-1:0]  part_q [ENTRIES];
    logic               real_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [IDX_W-1:0]   ptr_q;

    tlb_cmd_e cmd;
    assign cmd = tlb_cmd_e'(op_code);

    logic [ENTRIES-1:0] c_ovl, c_cov, c_ctx, c_part, c_space;
    logic [ENTRIES-1:0] l_cov, l_ctx, l_part, l_space, l_ovl;

    // Per-entry comparators: one against the command key, one against the lookup key
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_alloc_match #(.VPN_W(VPN_W), .CTX_W(CTX_W), .PART_W(PART_W), .STEP(STEP)) u_cmd (
            .e_vpn(vpn_q[g]), .e_size(size_q[g]), .e_ctx(ctx_q[g]), .e_part(part_q[g]), .e_real(real_q[g]),
            .k_vpn(op_vpn), .k_size(op_size), .k_ctx(op_ctx), .k_part(op_part), .k_real(op_real),
            .overlap(c_ovl[g]), .covers(c_cov[g]), .same_ctx(c_ctx[g]), .same_part(c_part[g]),
            .same_space(c_space[g]));
        tlb_alloc_match #(.VPN_W(VPN_W), .CTX_W(CTX_W), .PART_W(PART_W), .STEP(STEP)) u_look (
            .e_vpn(vpn_q[g]), .e_size(size_q[g]), .e_ctx(ctx_q[g]), .e_part(part_q[g]), .e_real(real_q[g]),
            .k_vpn(lk_vpn), .k_size(2'd0), .k_ctx(lk_ctx), .k_part(lk_part), .k_real(lk_real),
            .overlap(l_ovl[g]), .covers(l_cov[g]), .same_ctx(l_ctx[g]), .same_part(l_part[g]),
            .same_space(l_space[g]));
    end

    logic [ENTRIES-1:0] kill, valid_mid, free_vec;
    logic               do_ins;

    // Slots removed by the current command (conflicts on insert, demap matches)
    always_comb begin
        kill   = '0;
        do_ins = 1'b0;
        if (op_valid) begin
            case (cmd)
                CMD_INSERT: begin
                    kill   = valid_q & c_ovl & c_ctx & c_space;
                    do_ins = 1'b1;
                end
                CMD_DMAP_PAGE: kill = valid_q & c_cov & c_ctx & c_space;
                CMD_DMAP_CTX:  kill = valid_q & c_ctx & c_part;
                CMD_DMAP_PART: kill = valid_q & c_part & ~lock_q;
                CMD_FLUSH:     kill = valid_q;
                default:       kill = '0;
            endcase
        end
        valid_mid = valid_q & ~kill;
        free_vec  = ~valid_mid;
    end

    logic [IDX_W-1:0] victim;
    logic             advance;

    tlb_alloc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .free_vec(free_vec), .lock_vec(lock_q & valid_mid), .ptr(ptr_q),
        .at_idx(op_at_idx), .idx(op_idx), .victim(victim), .advance(advance));

    logic [ENTRIES-1:0] pick, valid_n, lock_n, used_n;

    // Next-state state bits, including the used-bit aging rule
    always_comb begin
        pick    = do_ins ? (ENTRIES'(1) << victim) : '0;
        valid_n = valid_mid | pick;
        lock_n  = (lock_q & valid_mid & ~pick) | (op_lock ? pick : '0);
        used_n  = (used_q & valid_mid) | pick;
        if (do_ins && (&used_n)) used_n = (lock_n & valid_n) | pick;
        if (op_valid && cmd == CMD_FLUSH) begin
            valid_n = '0;
            lock_n  = '0;
            used_n  = '0;
        end
    end

    // State-bit registers and replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            used_q  <= '0;
            lock_q  <= '0;
            ptr_q   <= '0;
        end else begin
            valid_q <= valid_n;
            used_q  <= used_n;
            lock_q  <= lock_n;
            if (do_ins && advance) ptr_q <= victim;
        end
    end

    // Entry payload written on insert into the chosen slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                size_q[i] <= '0;
                ctx_q[i]  <= '0;
                part_q[i] <= '0;
                real_q[i] <= 1'b0;
                ppn_q[i]  <= '0;
            end
        end else if (do_ins) begin
            vpn_q[victim]  <= op_vpn;
            size_q[victim] <= op_size;
            ctx_q[victim]  <= op_ctx;
            part_q[victim] <= op_part;
            real_q[victim] <= op_real;
            ppn_q[victim]  <= op_ppn;
        end
    end

    // Population count of the used bits
    always_comb begin
        used_count = '0;
        for (int i = 0; i < ENTRIES; i++) used_count = used_count + CNT_W'(used_q[i]);
    end

    // Lookup: lowest-indexed valid match drives the result
    always_comb begin
        logic [ENTRIES-1:0] hitv;
        hitv   = valid_q & l_cov & l_ctx & l_space;
        lk_hit = |hitv;
        lk_ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (hitv[i]) lk_ppn = ppn_q[i];
    end

    // Diagnostic read port
    always_comb begin
        rd_word = '1;
        if (valid_q[rd_idx]) begin
            if (!rd_sel) begin
                rd_word = 64'(ctx_q[rd_idx])
                        | (64'(vpn_q[rd_idx]) << TAG_VA_LSB)
                        | (64'(part_q[rd_idx]) << TAG_PART_LSB)
                        | (64'(real_q[rd_idx]) << TAG_REAL_BIT)
                        | (64'(3'b111 ^ {1'b0, size_q[rd_idx]}) << TAG_SIZE_LSB);
            end else begin
                rd_word = '0;
                rd_word[63] = 1'b1;
                rd_word[62] = lock_q[rd_idx];
                rd_word[TAG_VA_LSB +: PPN_W] = ppn_q[rd_idx];
                rd_word[1:0] = size_q[rd_idx];
            end
        end
    end

    // Assertions guarding the state update
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=> (valid_q == '0 && used_count == '0));

    p_free_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ins && !op_at_idx && (|free_vec)) |=> ($countones(valid_q) == $countones($past(valid_mid)) + 1));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_ins && advance) |=> $stable(ptr_q));

    p_part_keeps_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd4) |=> (($past(valid_q & lock_q) & ~valid_q) == '0));

    p_used_within_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((used_q & ~valid_q) == '0));

    p_hit_needs_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q != '0));

endmodule

// File: tb/tlb_alloc_test.sv
module tlb_alloc_test;

    localparam int CLK_PERIOD = 20;
    localparam int N     = 4;
    localparam int IW    = 2;
    localparam int CW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [19:0] op_vpn = '0;
    logic [1:0] op_size = '0;
    logic [12:0] op_ctx = '0;
    logic [2:0] op_part = '0;
    logic op_real = 1'b0, op_lock = 1'b0, op_at_idx = 1'b0;
    logic [23:0] op_ppn = '0;
    logic [IW-1:0] op_idx = '0;
    logic [19:0] lk_vpn = '0;
    logic [12:0] lk_ctx = '0;
    logic [2:0] lk_part = '0;
    logic lk_real = 1'b0;
    logic lk_hit;
    logic [23:0] lk_ppn;
    logic [IW-1:0] rd_idx = '0;
    logic rd_sel = 1'b0;
    logic [63:0] rd_word;
    logic [CW-1:0] used_count;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_alloc #(.ENTRIES(N), .VPN_W(20), .CTX_W(13), .PART_W(3), .PPN_W(24)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_vpn(op_vpn),
        .op_size(op_size), .op_ctx(op_ctx), .op_part(op_part), .op_real(op_real),
        .op_lock(op_lock), .op_ppn(op_ppn), .op_at_idx(op_at_idx), .op_idx(op_idx),
        .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .lk_part(lk_part), .lk_real(lk_real),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .rd_idx(rd_idx), .rd_sel(rd_sel),
        .rd_word(rd_word), .used_count(used_count));

    // Behavioural reference model
    bit m_valid[N], m_used[N], m_lock[N], m_real[N];
    int m_vpn[N], m_size[N], m_ctx[N], m_part[N], m_ppn[N];
    int m_ptr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    function automatic int msk(int s);
        return (1 << (3 * s)) - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_kill(int i);
        m_valid[i] = 0;
        m_used[i]  = 0;
        m_lock[i]  = 0;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < N; i++) m_kill(i);
        m_ptr = 0;
    endfunction

    function automatic void m_apply(int code, int vpn, int sz, int ctx, int part, bit rl,
                                    bit lk, int ppn, bit at, int idx);
        int v;
        bit all;
        bit found;
        if (code == 5) begin
            for (int i = 0; i < N; i++) m_kill(i);
            return;
        end
        for (int i = 0; i < N; i++) begin
            if (!m_valid[i]) continue;
            if (code == 1 && m_ctx[i] == ctx && m_part[i] == part && m_real[i] == rl &&
                ((m_vpn[i] ^ vpn) & ~(msk(m_size[i]) | msk(sz))) == 0) m_kill(i);
            else if (code == 2 && m_ctx[i] == ctx && m_part[i] == part && m_real[i] == rl &&
                ((m_vpn[i] ^ vpn) & ~msk(m_size[i])) == 0) m_kill(i);
            else if (code == 3 && m_ctx[i] == ctx && m_part[i] == part) m_kill(i);
            else if (code == 4 && m_part[i] == part && !m_lock[i]) m_kill(i);
        end
        if (code != 1) return;
        v = -1;
        if (at) v = idx;
        else begin
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
            if (v < 0) begin
                found = 0;
                for (int s = 1; s < N && !found; s++) begin
                    int x;
                    x = (m_ptr + s) % N;
                    if (!m_lock[x]) begin
                        found = 1;
                        v = x;
                        m_ptr = x;
                    end
                end
                if (!found) v = N - 1;
            end
        end
        m_valid[v] = 1; m_used[v] = 1; m_lock[v] = lk;
        m_vpn[v] = vpn; m_size[v] = sz; m_ctx[v] = ctx; m_part[v] = part;
        m_real[v] = rl; m_ppn[v] = ppn;
        all = 1;
        for (int i = 0; i < N; i++) if (!m_used[i]) all = 0;
        if (all) begin
            for (int i = 0; i < N; i++) m_used[i] = m_lock[i] && m_valid[i];
            m_used[v] = 1;
        end
    endfunction

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < N; i++) c += m_used[i];
        return c;
    endfunction

    // Per-clock comparison of used count (R9) and lookup outputs (R12)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int hit_i;
            hit_i = -1;
            chk(used_count == CW'(m_count()), "R9 used_count", 64'(used_count), 64'(m_count()));
            for (int i = N - 1; i >= 0; i--)
                if (m_valid[i] && m_ctx[i] == int'(lk_ctx) && m_part[i] == int'(lk_part) &&
                    m_real[i] == lk_real && ((m_vpn[i] ^ int'(lk_vpn)) & ~msk(m_size[i])) == 0)
                    hit_i = i;
            chk(lk_hit == (hit_i >= 0), "R12 lk_hit", 64'(lk_hit), 64'(hit_i >= 0));
            if (hit_i >= 0)
                chk(lk_ppn == 24'(m_ppn[hit_i]), "R12 lk_ppn", 64'(lk_ppn), 64'(m_ppn[hit_i]));
        end
    end

    // Reads every slot through the port and compares tag (R10) and data (R11) words
    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) begin
            logic [63:0] et, ed;
            if (m_valid[i]) begin
                et = 64'(m_ctx[i]) | (64'(m_vpn[i]) << 13) | (64'(m_part[i]) << 61) |
                     (64'(m_real[i]) << 60) | (64'(7 ^ m_size[i]) << 56);
                ed = (64'(1) << 63) | (64'(m_lock[i]) << 62) | (64'(m_ppn[i]) << 13) | 64'(m_size[i]);
            end else begin
                et = '1;
                ed = '1;
            end
            rd_idx = IW'(i); rd_sel = 1'b0; #1;
            chk(rd_word === et, {req, " R10 tag"}, rd_word, et);
            rd_sel = 1'b1; #1;
            chk(rd_word === ed, {req, " R11 data"}, rd_word, ed);
        end
    endtask

    // Drives one command at a falling edge and updates the model at the rising edge
    task automatic do_op(input int code, input int vpn, input int sz, input int ctx, input int part,
                         input bit rl, input bit lk, input int ppn, input bit at, input int idx,
                         input string req);
        op_valid = 1'b1; op_code = 3'(code); op_vpn = 20'(vpn); op_size = 2'(sz);
        op_ctx = 13'(ctx); op_part = 3'(part); op_real = rl; op_lock = lk; op_ppn = 24'(ppn);
        op_at_idx = at; op_idx = IW'(idx);
        @(posedge clk);
        m_apply(code, vpn, sz, ctx, part, rl, lk, ppn, at, idx);
        @(negedge clk);
        op_valid = 1'b0;
        check_all(req);
        @(negedge clk);
    endtask

    task automatic set_lk(input int vpn, input int ctx, input int part, input bit rl);
        @(posedge clk); #1;
        lk_vpn = 20'(vpn); lk_ctx = 13'(ctx); lk_part = 3'(part); lk_real = rl;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(used_count == 0, "R1 used_count", 64'(used_count), 0);
        check_all("R1");
        // R2: lowest free slot
        do_op(1, 'h100, 0, 5, 1, 0, 0, 'h1111, 0, 0, "R2");
        do_op(1, 'h200, 0, 5, 1, 0, 0, 'h2222, 0, 0, "R2");
        do_op(1, 'h300, 0, 5, 1, 0, 0, 'h3333, 0, 0, "R2");
        do_op(1, 'h400, 0, 5, 1, 0, 0, 'h4444, 0, 0, "R2 R9 aging");
        // R3: overlapping size-1 entry replaces slot 1 in place
        do_op(1, 'h203, 1, 5, 1, 0, 0, 'h5555, 0, 0, "R3");
        set_lk('h205, 5, 1, 0);   // R12 covered offset
        set_lk('h205, 6, 1, 0);   // R12 context miss
        // R4: explicit index
        do_op(1, 'h500, 0, 5, 1, 0, 0, 'h6666, 1, 2, "R4");
        // lock slots 0 and 1 through explicit inserts
        do_op(1, 'h600, 0, 5, 1, 0, 1, 'h7000, 1, 0, "R4 lock");
        do_op(1, 'h700, 0, 7, 1, 0, 1, 'h7001, 1, 1, "R4 lock");
        // R5: rotation skips locked slots
        do_op(1, 'h800, 0, 5, 1, 0, 0, 'h8000, 0, 0, "R5");
        do_op(1, 'h900, 0, 5, 1, 0, 0, 'h9000, 0, 0, "R5");
        do_op(1, 'hA00, 0, 5, 1, 0, 0, 'hA000, 0, 0, "R5 wrap");
        // R6: all locked except the pointer position
        do_op(1, 'hB00, 0, 5, 1, 0, 1, 'hB000, 1, 2, "R6 lock");
        do_op(1, 'hC00, 0, 5, 1, 0, 1, 'hC000, 1, 3, "R6 lock");
        do_op(1, 'hD00, 0, 5, 1, 0, 0, 'hD000, 0, 0, "R6");
        set_lk('hB00, 5, 1, 0);   // R12 hit
        // R7: partition demap with other partition has no effect, then real one
        do_op(4, 0, 0, 0, 2, 0, 0, 0, 0, 0, "R7 other partition");
        do_op(4, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 partition");
        do_op(2, 'h600, 0, 5, 1, 0, 0, 0, 0, 0, "R7 page locked");
        do_op(3, 0, 0, 7, 1, 0, 0, 0, 0, 0, "R7 context locked");
        do_op(1, 'hE00, 0, 5, 1, 1, 0, 'hE000, 0, 0, "R2 refill");
        // R8: flush
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        chk(used_count == 0, "R8 used_count", 64'(used_count), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'(0), 64'(1));
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule